// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the single 8-bit control register that stands between a host and the programming and erase machinery of an on-chip flash array. The host writes it through a simple register port: a write strobe, write data and a read-back bus. An external write-allow pin is the hardware interlock. The top bit of the register is not stored. It always shows the live pin level. A low pin means the array is hardware-protected.

The low seven bits hold a software enable and six setup and mode bits. A bit accepts a write only when a chain of interlocks is met. The pin must be high. The software enable must already be set. The erase setup bit must not be raised in the same write that raises another bit. When these conditions fail, the affected bits keep their old value.

The stored bits drive decoded outputs: erase setup, program setup, erase, program, erase-verify and program-verify. When all seven low bits are zero, the flash is read as plain ROM and no mode output is active.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, bits 6..0 are 0, `rd_data` reads `{pin,7'b0}`, and every mode and setup output is 0.
- R2: `rd_data[7]` always equals the current level of `wr_allow_pin`, and a write cannot change it.
- R3: Bit 6 is the software enable (SWE). A write with `wr_data[6]=1` sets it only while the pin is high. While SWE is 0, bits 5..0 stay 0 whatever is written.
- R4: The bit positions are: 5 = erase setup (ESU), 4 = program setup (PSU), 3 = erase-verify (EV), 2 = program-verify (PV), 1 = erase (E), 0 = program (P). Bits 4..0 take the written value only when the pin is high, stored SWE is 1, and the write keeps `wr_data[6]=1`.
- R5: ESU is rejected, and keeps its old value, when a write would raise it from 0 while the same write also raises any of bits 4..0 from 0. The other bits of that write are still accepted.
- R6: A write with `wr_data[6]=0` while the pin is high clears SWE and bits 5..0 at the same clock edge.
- R7: While the pin is low, `rd_data[6:0]` reads 0 at once, and the stored bits are cleared at the next edge. Writes made while the pin is low are ignored, so the bits are still 0 when the pin returns high.
- R8: The mode outputs decode as follows: `erase_mode` = E and ESU; `prog_mode` = P and PSU; `erase_verify` = EV; `prog_verify` = PV. If more than one of these four would be active, all four read 0.
- R9: `erase_setup` and `prog_setup` show the effective ESU and PSU bits.
- R10: When bits 6..0 are all 0, no mode output is active.
- R11: A cycle with `wr_en` low leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_allow_pin | input | 1 | External write-allow pin; low means hardware protection |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back: pin level and the effective bits 6..0 |
| erase_setup | output | 1 | Erase setup bit active |
| prog_setup | output | 1 | Program setup bit active |
| erase_mode | output | 1 | Erase mode selected |
| prog_mode | output | 1 | Program mode selected |
| erase_verify | output | 1 | Erase-verify mode selected |
| prog_verify | output | 1 | Program-verify mode selected |

## Verification
The bench tries to set SWE while the pin is low. A design that ignores the pin would report a writable register under hardware protection. It writes the erase setup bit together with newly raised program, verify or erase bits. A design without the exclusivity check would latch ESU, or would wrongly discard the other bits of the write. It drops the pin with bits set and checks the read-back before the next edge. A registered-only clear would expose stale enable bits for one cycle. It also builds conflicting program and verify combinations, where a design without the suppression rule would drive two mode outputs at once.

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_allow_pin,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       erase_setup,
  output logic       prog_setup,
  output logic       erase_mode,
  output logic       prog_mode,
  output logic       erase_verify,
  output logic       prog_verify
);
  // bit map: 6 swe, 5 esu, 4 psu, 3 ev, 2 pv, 1 e, 0 p
  logic [6:0] q, nq, eff;
  logic [4:0] raised;
  logic       esu_block;
  logic [3:0] cand;

  assign raised    = wr_data[4:0] & ~q[4:0];
  assign esu_block = wr_data[5] & ~q[5] & (|raised);

  always_comb begin
    nq = q;
    if (!wr_allow_pin)
      nq = '0;
    else if (wr_en) begin
      if (!wr_data[6])
        nq = '0;
      else if (!q[6])
        nq = 7'b100_0000;
      else
        nq = {1'b1, (esu_block ? q[5] : wr_data[5]), wr_data[4:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nq;

  assign eff     = wr_allow_pin ? q : 7'b0;
  assign rd_data = {wr_allow_pin, eff};

  assign erase_setup = eff[5];
  assign prog_setup  = eff[4];

  assign cand = {eff[1] & eff[5], eff[0] & eff[4], eff[3], eff[2]};
  wire   single = ((cand & (cand - 4'd1)) == 4'd0);
  assign {erase_mode, prog_mode, erase_verify, prog_verify} = single ? cand : 4'b0;

  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow_pin |=> (q == 7'b0)); // R7
  AST_SWE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!q[6] && !(wr_allow_pin && wr_en && wr_data[6])) |=> !q[6]); // R3
  AST_LOW_BITS_NEED_SWE: assert property (@(posedge clk) disable iff (!rst_n)
    !q[6] |-> (q[5:0] == 6'b0)); // R3
  AST_ESU_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow_pin && wr_en && wr_data[6] && wr_data[5] && !q[5] && ((wr_data[4:0] & ~q[4:0]) != 5'b0))
      |=> !q[5]); // R5
  AST_SWE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow_pin && wr_en && !wr_data[6]) |=> (q == 7'b0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow_pin && !wr_en) |=> $stable(q)); // R11
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_mode, prog_mode, erase_verify, prog_verify})); // R8
  AST_IDLE_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:0] == 7'b0) |-> !(erase_mode || prog_mode || erase_verify || prog_verify)); // R10
endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b1, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic esu_o, psu_o, er_o, pr_o, ev_o, pv_o;
  int checks = 0, fails = 0;
  logic [6:0] model = 7'b0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] rd;
    logic [5:0] outs;
    logic [7:0] req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  flash_pe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_allow_pin(pin), .wr_en(we), .wr_data(wd),
    .rd_data(rd), .erase_setup(esu_o), .prog_setup(psu_o), .erase_mode(er_o),
    .prog_mode(pr_o), .erase_verify(ev_o), .prog_verify(pv_o));

  function automatic logic [6:0] next_bits(logic [6:0] s, logic p, logic w, logic [7:0] d);
    logic [6:0] r;
    logic [4:0] up;
    if (!p) return 7'b0;
    if (!w) return s;
    if (!d[6]) return 7'b0;
    if (!s[6]) return 7'b100_0000;
    up = d[4:0] & ~s[4:0];
    r = {1'b1, d[5], d[4:0]};
    if (d[5] && !s[5] && up != 5'b0) r[5] = s[5];
    return r;
  endfunction

  function automatic logic [5:0] exp_outs(logic [6:0] b);
    logic [3:0] c;
    int n;
    c = {b[1] & b[5], b[0] & b[4], b[3], b[2]};
    n = int'(c[0]) + int'(c[1]) + int'(c[2]) + int'(c[3]);
    if (n > 1) c = 4'b0;
    return {b[5], b[4], c};
  endfunction

  function automatic logic [5:0] got_outs();
    return {esu_o, psu_o, er_o, pr_o, ev_o, pv_o};
  endfunction

  task automatic compare(string req, logic [7:0] ard, logic [5:0] aout, logic [7:0] erd, logic [5:0] eout);
    checks++;
    if (ard !== erd || aout !== eout) begin
      fails++;
      $display("FAIL %s: rd=%h outs=%b expected rd=%h outs=%b", req, ard, aout, erd, eout);
    end
  endtask

  task automatic step(logic p, logic w, logic [7:0] d, logic [7:0] tag);
    exp_t e;
    logic [6:0] vis;
    @(negedge clk);
    pin = p; we = w; wd = d;
    #1;
    vis = p ? model : 7'b0;
    compare("R7/R2 immediate", rd, got_outs(), {p, vis}, exp_outs(vis));
    model = next_bits(model, p, w, d);
    @(posedge clk);
    #2;
    vis = p ? model : 7'b0;
    e.rd = {p, vis};
    e.outs = exp_outs(vis);
    e.req = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #6;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        compare($sformatf("R%0d", e.req), rd, got_outs(), e.rd, e.outs);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: rd=%h expected run end", rd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #5;
    compare("R1 reset", rd, got_outs(), 8'h80, 6'b0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h00, 8'd10);  // R10 idle, no mode
    step(1'b0, 1'b1, 8'h40, 8'd3);   // R3 SWE blocked while pin low
    step(1'b1, 1'b1, 8'h7F, 8'd3);   // R3 only SWE sets
    step(1'b1, 1'b1, 8'h60, 8'd9);   // R9 ESU alone
    step(1'b1, 1'b1, 8'h62, 8'd8);   // R8 erase mode
    step(1'b1, 1'b0, 8'h00, 8'd11);  // R11 no write
    step(1'b1, 1'b1, 8'h40, 8'd4);   // R4 clear low bits
    step(1'b1, 1'b1, 8'h71, 8'd5);   // R5 ESU rejected, PSU+P taken
    step(1'b1, 1'b1, 8'h79, 8'd8);   // R8 program+EV conflict -> none
    step(1'b1, 1'b1, 8'h40, 8'd4);   // R4
    step(1'b1, 1'b1, 8'h68, 8'd5);   // R5 ESU rejected with EV
    step(1'b1, 1'b1, 8'h68, 8'd5);   // R5 EV already set, ESU now accepted
    step(1'b1, 1'b1, 8'h04, 8'd6);   // R6 SWE clear wipes all
    step(1'b1, 1'b1, 8'h44, 8'd4);   // R4 PV blocked, SWE was 0
    step(1'b1, 1'b1, 8'h44, 8'd8);   // R8 program-verify
    step(1'b0, 1'b0, 8'h00, 8'd7);   // R7 pin low clears
    step(1'b0, 1'b1, 8'h7F, 8'd7);   // R7 write ignored
    step(1'b1, 1'b0, 8'h00, 8'd7);   // R7 stays zero after return
    step(1'b1, 1'b1, 8'hC0, 8'd2);   // R2 bit7 not writable
    step(1'b1, 1'b1, 8'h00, 8'd10);  // R10 all zero
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule